// File: doc/BRIEF.md
# Instruction Cache Invalidation Sequencer

This block sits beside the tag array of a small set-associative instruction cache. It holds the cache control register and a hardware sequencer that wipes every tag entry. Software writes a one to the invalidate field. The sequencer then spends a few preparation cycles, walks the sets in ascending order and writes all ways of one set per cycle. Each written entry has a zero tag, a cleared valid bit and check bits chosen by the error-detection mode. When the walk is done the invalidate field clears itself.

The mode that governs the check bits is captured at the moment the sweep starts. Later register writes can change the enable bit and the mode field during a sweep without disturbing it. An abort input ends a sweep early. Taking an abort clears the invalidate field and raises a sticky flag that only software can clear. The sweep runs whether the cache is enabled or not. The enable bit only drives the lookup-enable output.

Top module: `cache_inval_ctrl`

## Requirements
- R1: After synchronous reset the register reads 0, busy is 0 and no tag write is issued.
- R2: Register fields: bit 0 cache enable, bit 1 invalidate, bit 2 sticky abort flag, bits 4:3 error-detection mode. Bits 31:5 read 0 and ignore writes.
- R3: A write with bit 1 set while idle starts a sweep. Busy and the invalidate bit read 1 from the next cycle.
- R4: Three cycles after the start cycle, tag_we is high for 128 consecutive cycles. tag_set runs 0, 1, ..., 127, and tag_way_mask is all ones (4'hF).
- R5: Two cycles after the last set is written, busy drops and bit 1 reads 0. A full sweep holds busy for exactly 133 cycles.
- R6: While busy, writing either 0 or 1 to bit 1 has no effect. The sweep neither stops nor restarts.
- R7: Each written entry is {check[3:0], valid=0, tag[19:0]=0}. The check bits are 4'h0 for mode 0 (none), 4'hF for mode 1 (odd parity), 4'h5 for mode 2 (code) and 4'h0 for mode 3 (reserved).
- R8: The mode used for check bits is the mode field value in the starting write. Writes to the mode field during the sweep do not change it.
- R9: The sweep runs with the enable bit at 0 or 1. lookup_en follows bit 0, and bit 0 stays writable while busy.
- R10: abort_req high while busy returns the block to idle at the next edge. At that edge bit 1 clears, bit 2 sets and tag writes stop.
- R11: The abort flag stays set until a write with bit 2 = 0. A write with bit 2 = 1 does not set it, a hardware abort wins over a same-cycle clear, and abort_req while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| abort_req | input | 1 | Request to abort a sweep in progress |
| lookup_en | output | 1 | Cache enable to the lookup logic |
| busy | output | 1 | Sweep in progress |
| tag_we | output | 1 | Tag array write enable |
| tag_set | output | 7 | Set index being written |
| tag_way_mask | output | 4 | Ways written this cycle |
| tag_wdata | output | 25 | Entry written: check bits, valid, tag |

## Verification
The hardest cases to reach from the ports are races at single edges. One is an abort on the same edge as a software clear of the abort flag. Another is an invalidate write that lands while a sweep is already running. The stimulus places register writes and abort pulses at exact cycle offsets from a start. These offsets cover the preparation phase, the middle of the set walk and the idle state. A behavioural model predicts every output on every cycle, including the check-bit value the captured mode should give after the mode field has been rewritten mid-sweep.

// File: rtl/icinv_pkg.sv
package icinv_pkg;

    localparam int REG_W   = 32;
    localparam int FIELD_W = 5;
    localparam int CHK_W   = 4;

    typedef enum logic [1:0] {
        EDT_NONE   = 2'd0,
        EDT_PARITY = 2'd1,
        EDT_CODE   = 2'd2,
        EDT_RSVD   = 2'd3
    } edt_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PREP,
        SQ_SWEEP,
        SQ_FINISH
    } seq_state_e;

    typedef struct packed {
        edt_mode_e mode;
        logic      abt;
        logic      inv;
        logic      en;
    } ctrl_fields_t;

    function automatic logic [CHK_W-1:0] clear_check(edt_mode_e m);
        logic [CHK_W-1:0] v;
        case (m)
            EDT_PARITY: v = '1;
            EDT_CODE:   v = {(CHK_W/2){2'b01}};
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/icinv_regs.sv
module icinv_regs
    import icinv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  ctrl_fields_t     wfields_i,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic             abort_taken_i,
    output logic             start_o,
    output edt_mode_e        start_mode_o,
    output logic             en_o,
    output logic [REG_W-1:0] rdata_o
);

    ctrl_fields_t q;

    assign start_o      = wr_i && wfields_i.inv && !busy_i;
    assign start_mode_o = wfields_i.mode;
    assign en_o         = q.en;
    assign rdata_o      = {{(REG_W-FIELD_W){1'b0}}, q};

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (wr_i) begin
                q.en   <= wfields_i.en;
                q.mode <= wfields_i.mode;
            end
            if (start_o)
                q.inv <= 1'b1;
            else if (done_i || abort_taken_i)
                q.inv <= 1'b0;
            if (abort_taken_i)
                q.abt <= 1'b1;
            else if (wr_i && !wfields_i.abt)
                q.abt <= 1'b0;
        end
    end

    // R3
    inv_tracks_busy_chk: assert property (@(posedge clk) disable iff (rst)
        q.inv == busy_i);

    // R10
    abort_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        abort_taken_i |=> (q.abt && !q.inv));

    // R11
    abort_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (q.abt && !(wr_i && !wfields_i.abt)) |=> q.abt);

endmodule

// File: rtl/icinv_seq.sv
module icinv_seq
    import icinv_pkg::*;
#(
    parameter int NUM_SETS = 128,
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 20,
    parameter int PRE_CYC  = 3,
    parameter int POST_CYC = 2,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int ENTRY_W = CHK_W + 1 + TAG_W,
    localparam int OVH_MAX = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC,
    localparam int OVH_W   = $clog2(OVH_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  edt_mode_e           mode_i,
    input  logic                abort_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                abort_taken_o,
    output logic                tag_we_o,
    output logic [SET_W-1:0]    tag_set_o,
    output logic [NUM_WAYS-1:0] tag_mask_o,
    output logic [ENTRY_W-1:0]  tag_wdata_o
);

    seq_state_e       state_q;
    logic [OVH_W-1:0] cnt_q;
    logic [SET_W-1:0] set_q;
    edt_mode_e        mode_q;

    localparam logic [SET_W-1:0] LAST_SET  = SET_W'(NUM_SETS - 1);
    localparam logic [OVH_W-1:0] PRE_LAST  = OVH_W'(PRE_CYC - 1);
    localparam logic [OVH_W-1:0] POST_LAST = OVH_W'(POST_CYC - 1);

    assign busy_o        = (state_q != SQ_IDLE);
    assign abort_taken_o = busy_o && abort_i;
    assign done_o        = (state_q == SQ_FINISH) && (cnt_q == POST_LAST) && !abort_i;
    assign tag_we_o      = (state_q == SQ_SWEEP);
    assign tag_set_o     = set_q;
    assign tag_mask_o    = '1;
    assign tag_wdata_o   = {clear_check(mode_q), 1'b0, {TAG_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            set_q   <= '0;
            mode_q  <= EDT_NONE;
        end else if (abort_taken_o) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            set_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (start_i) begin
                    state_q <= SQ_PREP;
                    cnt_q   <= '0;
                    mode_q  <= mode_i;
                end
                SQ_PREP: if (cnt_q == PRE_LAST) begin
                    state_q <= SQ_SWEEP;
                    set_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                SQ_SWEEP: if (set_q == LAST_SET) begin
                    state_q <= SQ_FINISH;
                    cnt_q   <= '0;
                end else begin
                    set_q <= set_q + 1'b1;
                end
                SQ_FINISH: if (cnt_q == POST_LAST) begin
                    state_q <= SQ_IDLE;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R4
    set_ascends_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_we_o && $past(tag_we_o)) |-> (tag_set_o == SET_W'($past(tag_set_o) + 1'b1)));

    // R8
    mode_held_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(mode_q));

    // R10
    abort_idles_chk: assert property (@(posedge clk) disable iff (rst)
        abort_taken_o |=> (!busy_o && !tag_we_o));

endmodule

// File: rtl/cache_inval_ctrl.sv
module cache_inval_ctrl
    import icinv_pkg::*;
#(
    parameter int NUM_SETS = 128,
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 20,
    parameter int PRE_CYC  = 3,
    parameter int POST_CYC = 2,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int ENTRY_W = CHK_W + 1 + TAG_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                abort_req,
    output logic                lookup_en,
    output logic                busy,
    output logic                tag_we,
    output logic [SET_W-1:0]    tag_set,
    output logic [NUM_WAYS-1:0] tag_way_mask,
    output logic [ENTRY_W-1:0]  tag_wdata
);

    ctrl_fields_t wfields;
    logic         start, done, abort_taken;
    edt_mode_e    start_mode;
    logic         unused_hi;

    assign wfields   = ctrl_fields_t'(reg_wdata[FIELD_W-1:0]);
    assign unused_hi = ^reg_wdata[REG_W-1:FIELD_W];

    icinv_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_i          (reg_wr),
        .wfields_i     (wfields),
        .busy_i        (busy),
        .done_i        (done),
        .abort_taken_i (abort_taken),
        .start_o       (start),
        .start_mode_o  (start_mode),
        .en_o          (lookup_en),
        .rdata_o       (reg_rdata)
    );

    icinv_seq #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W),
        .PRE_CYC  (PRE_CYC),
        .POST_CYC (POST_CYC)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .mode_i        (start_mode),
        .abort_i       (abort_req),
        .busy_o        (busy),
        .done_o        (done),
        .abort_taken_o (abort_taken),
        .tag_we_o      (tag_we),
        .tag_set_o     (tag_set),
        .tag_mask_o    (tag_way_mask),
        .tag_wdata_o   (tag_wdata)
    );

endmodule

// File: tb/tb_cache_inval_ctrl.sv
module tb_cache_inval_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SETS  = 128;
    localparam int PRE   = 3;
    localparam int POST  = 2;
    localparam int TOTAL = PRE + SETS + POST;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        abort_req = 1'b0;
    logic [31:0] reg_rdata;
    logic        lookup_en, busy, tag_we;
    logic [6:0]  tag_set;
    logic [3:0]  tag_way_mask;
    logic [24:0] tag_wdata;

    cache_inval_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .abort_req(abort_req), .lookup_en(lookup_en),
        .busy(busy), .tag_we(tag_we), .tag_set(tag_set),
        .tag_way_mask(tag_way_mask), .tag_wdata(tag_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit started = 0;

    // behavioural model
    bit m_en, m_inv, m_abt;
    int m_mode, m_lmode;
    int m_step = -1;

    int run = 0, last_run = 0, wr_run = 0, last_wr_run = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_chk(int mode);
        case (mode)
            1: return 4'hF;
            2: return 4'h5;
            default: return 4'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_en = 0; m_inv = 0; m_abt = 0; m_mode = 0; m_lmode = 0; m_step = -1;
        end else begin
            bit hw_abort;
            hw_abort = (m_step >= 0) && abort_req;
            if (reg_wr) begin
                m_en = reg_wdata[0];
                m_mode = int'(reg_wdata[4:3]);
                if (!reg_wdata[2] && !hw_abort) m_abt = 0;
            end
            if (m_step >= 0) begin
                if (abort_req) begin
                    m_step = -1; m_inv = 0; m_abt = 1;
                end else if (m_step == TOTAL - 1) begin
                    m_step = -1; m_inv = 0;
                end else begin
                    m_step++;
                end
            end else if (reg_wr && reg_wdata[1]) begin
                m_step = 0; m_inv = 1; m_lmode = int'(reg_wdata[4:3]);
            end
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            bit exp_we;
            exp_we = (m_step >= PRE) && (m_step < PRE + SETS);
            check("R2 rdata", reg_rdata,
                  {27'b0, 2'(m_mode), m_abt, m_inv, m_en});
            check("R9 lookup_en", {31'b0, lookup_en}, {31'b0, m_en});
            check("R5 busy", {31'b0, busy}, {31'b0, (m_step >= 0)});
            check("R4 tag_we", {31'b0, tag_we}, {31'b0, exp_we});
            if (exp_we) begin
                check("R4 tag_set", {25'b0, tag_set}, 32'(m_step - PRE));
                check("R4 tag_way_mask", {28'b0, tag_way_mask}, 32'hF);
                check("R7 tag_wdata", {7'b0, tag_wdata},
                      {7'b0, exp_chk(m_lmode), 21'b0});
            end
            if (busy) begin
                run++;
                if (tag_we) wr_run++;
            end else if (run != 0) begin
                last_run = run; last_wr_run = wr_run; run = 0; wr_run = 0;
            end
        end
    end

    task automatic wr_reg(logic [31:0] d);
        @(posedge clk); #1; reg_wr = 1; reg_wdata = d;
        @(posedge clk); #1; reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse_abort();
        @(posedge clk); #1; abort_req = 1;
        @(posedge clk); #1; abort_req = 0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 busy", {31'b0, busy}, 32'h0);
        check("R1 tag_we", {31'b0, tag_we}, 32'h0);

        // R2 field layout, upper bits ignored
        wr_reg(32'hFFFF_FFE0 | 32'h19);
        @(negedge clk);
        check("R2 readback", reg_rdata, 32'h19);

        // R3 start with enable 0, parity mode; R9 sweep with enable off
        wr_reg(32'h0000_000A);
        @(negedge clk);
        check("R3 inv set", {31'b0, reg_rdata[1]}, 32'h1);
        check("R3 busy", {31'b0, busy}, 32'h1);
        idle(12);
        // R6 write 0 to inv while busy; R8 change mode; R9 toggle enable
        wr_reg(32'h0000_0011);
        @(negedge clk);
        check("R6 still busy after zero write", {31'b0, busy}, 32'h1);
        idle(20);
        // R6 write 1 to inv while busy: no restart
        wr_reg(32'h0000_0002);
        idle(TOTAL);
        @(negedge clk);
        check("R5 full run length", 32'(last_run), 32'(TOTAL));
        check("R4 writes per run", 32'(last_wr_run), 32'(SETS));
        check("R5 inv cleared", {31'b0, reg_rdata[1]}, 32'h0);

        // R7 code mode with enable on
        wr_reg(32'h0000_0013);
        idle(TOTAL + 2);
        @(negedge clk);
        check("R9 run with enable on", 32'(last_run), 32'(TOTAL));

        // R7 reserved mode
        wr_reg(32'h0000_001A);
        idle(TOTAL + 2);

        // R10 abort mid sweep
        wr_reg(32'h0000_0002);
        idle(40);
        pulse_abort();
        @(negedge clk);
        check("R10 busy cleared", {31'b0, busy}, 32'h0);
        check("R10 flags", {29'b0, reg_rdata[2:0]}, 32'h4);
        // R11 write 1 to abort flag keeps it; abort while idle ignored
        wr_reg(32'h0000_0004);
        pulse_abort();
        @(negedge clk);
        check("R11 flag kept", {31'b0, reg_rdata[2]}, 32'h1);
        check("R11 idle abort no start", {31'b0, busy}, 32'h0);
        wr_reg(32'h0000_0000);
        @(negedge clk);
        check("R11 flag cleared", {31'b0, reg_rdata[2]}, 32'h0);

        // R10 abort during preparation; R11 same-cycle clear loses
        wr_reg(32'h0000_000A);
        @(posedge clk); #1;
        reg_wr = 1; reg_wdata = 32'h0000_0008; abort_req = 1;
        @(posedge clk); #1;
        reg_wr = 0; reg_wdata = '0; abort_req = 0;
        @(negedge clk);
        check("R11 hw set wins", {31'b0, reg_rdata[2]}, 32'h1);
        check("R10 prep abort idle", {31'b0, busy}, 32'h0);
        // R11 abort while idle with flag clear
        wr_reg(32'h0000_0000);
        pulse_abort();
        @(negedge clk);
        check("R11 idle abort no flag", {31'b0, reg_rdata[2]}, 32'h0);
        idle(2);

        finished = 1;
        summary();
    end

endmodule